// File: doc/BRIEF.md
# PMIC Serial Bus Bridge

This block connects a memory-mapped host to the 16-bit registers of a companion power-management chip through a four-wire serial link. Any host write that lands in the 4 KB slave window is placed in a write queue. The queue sends its entries one at a time, oldest first, each as its own serial frame. To read a slave register, the host writes the register address to a read-command location. It then polls a single result word. That word carries a busy flag, the echoed low address bits and the returned 16-bit value.

Two small state machines do the work. The sequencer has the states C_IDLE, C_WR and C_RD. In C_IDLE a waiting queue entry always goes before a waiting read: C_IDLE→C_WR pops the queue, and C_IDLE→C_RD happens only when the queue is empty and a read is pending. C_WR→C_IDLE and C_RD→C_IDLE follow when the frame-complete strobe arrives. The link shifter has the states SH_IDLE, SH_SHIFT and SH_GAP. SH_IDLE→SH_SHIFT happens on a start request. SH_SHIFT→SH_GAP follows after the 29th bit period. SH_GAP→SH_IDLE follows after a select-high gap of one bit period, and that is when the shifter reports completion.

A frame is 29 bits, sent most significant bit first. The first bit is direction (1 = read, 0 = write). Next come 12 address bits, then 16 data bits. On a read, the slave drives the 16 data bits on the return line.

Top module: `pmic_bridge`

## Requirements
- R1: After reset, the read-result word (offset 0x2C) reads 0. The queue status word (offset 0x30) reads 0x400, which is the empty flag only. `link_csn` is high and `link_sclk` is low.
- R2: A host write to byte address 0x8000–0x8FFF sends one write frame: direction bit 0, address = bus address bits 11:0, data = write data bits 15:0. Host writes to addresses that are neither in this window nor the read-command offset produce no frame.
- R3: Queued writes go out on the link in the order the host issued them.
- R4: The queue holds 8 entries. The status word shows bit 11 = full and bit 10 = empty. A window write while the queue is full is dropped and sets bit 0, a sticky overflow flag that only reset clears.
- R5: A host write to offset 0x28 starts a read of address bits 11:0 of the write data. Bit 31 (busy) of the result word reads 1 from the next cycle and stays 1 until the read frame has finished.
- R6: When busy clears, the result word holds the slave data in bits 15:0 and the requested 12-bit address in bits 27:16. Bits 30:28 are 0.
- R7: A read command written while busy is 1 is ignored. No extra frame is sent, and the pending result is not changed.
- R8: A read frame starts only once the queue is empty. A read issued right after writes to the same slave register therefore returns the newly written value.
- R9: `link_sclk` runs at the system clock divided by 4, with 2 cycles low and then 2 cycles high per bit. It idles low while `link_csn` is high. `link_csn` stays low for exactly 29 bit periods per frame and stays high for at least 4 cycles between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 16 | Host byte address |
| bus_wdata | input | 16 | Host write data (slave data or read-command address) |
| bus_rdata | output | 32 | Host read data, combinational from `bus_addr` |
| link_sclk | output | 1 | Serial link clock |
| link_csn | output | 1 | Serial link select, active low for a whole frame |
| link_mosi | output | 1 | Serial data to the slave |
| link_miso | input | 1 | Serial data from the slave |

## Verification
The bench attaches a behavioural slave. The slave holds a register file and logs every write frame it decodes.

Single directed writes isolate the frame layout. Bursts of ten back-to-back window writes against one slow frame pin down the full boundary, the dropped push and the sticky flag. Writes immediately followed by a read of the same register separate correct queue ordering from a read that overtakes the queue.

A second read command issued during a busy read shows whether a command is wrongly accepted. A seeded random mix of window writes and reads, drawn from a small hot address pool and from the whole 4 KB range, compares results and the write log against a bench model of the slave.

// File: rtl/pmic_bridge_pkg.sv
`timescale 1ns/1ps
package pmic_bridge_pkg;

    localparam int SADDR_W = 12;
    localparam int SDATA_W = 16;
    localparam int FRAME_W = 1 + SADDR_W + SDATA_W;

    localparam logic [15:0] OFF_RD_CMD   = 16'h0028;
    localparam logic [15:0] OFF_RD_DATA  = 16'h002C;
    localparam logic [15:0] OFF_FIFO_STS = 16'h0030;
    localparam logic [3:0]  WIN_TAG      = 4'h8;

    localparam int STS_FULL_BIT  = 11;
    localparam int STS_EMPTY_BIT = 10;
    localparam int STS_OVF_BIT   = 0;

    typedef struct packed {
        logic [SADDR_W-1:0] addr;
        logic [SDATA_W-1:0] data;
    } wr_entry_t;

    localparam int ENTRY_W = $bits(wr_entry_t);

    typedef enum logic [1:0] {
        C_IDLE,
        C_WR,
        C_RD
    } ctl_state_t;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_SHIFT,
        SH_GAP
    } sh_state_t;

endpackage

// File: rtl/bridge_wfifo.sv
`timescale 1ns/1ps
module bridge_wfifo #(
    parameter int DEPTH = 8,
    parameter int W     = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic          push_ok;
    logic          pop_ok;

    assign full    = (count == CNT_FULL);
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            store[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/bridge_link_shifter.sv
`timescale 1ns/1ps
module bridge_link_shifter
    import pmic_bridge_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    output logic               done,
    output logic [SDATA_W-1:0] rx_data,
    output logic               sclk,
    output logic               csn,
    output logic               mosi,
    input  logic               miso
);
    localparam int HALF = CLK_DIV / 2;
    localparam int PH_W = $clog2(CLK_DIV);
    localparam int BC_W = $clog2(FRAME_W + 1);
    localparam int GAP  = CLK_DIV;
    localparam int GC_W = $clog2(GAP);

    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(CLK_DIV - 1);
    localparam logic [PH_W-1:0] PH_SAMP  = PH_W'(HALF - 1);
    localparam logic [PH_W-1:0] PH_HIGH  = PH_W'(HALF);
    localparam logic [BC_W-1:0] BIT_LAST = BC_W'(FRAME_W - 1);
    localparam logic [GC_W-1:0] GAP_LAST = GC_W'(GAP - 1);

    sh_state_t          state;
    sh_state_t          state_nx;
    logic [PH_W-1:0]    phase;
    logic [BC_W-1:0]    bit_cnt;
    logic [GC_W-1:0]    gap_cnt;
    logic [FRAME_W-1:0] shreg;
    logic [SDATA_W-1:0] rx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SH_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            SH_IDLE: begin
                if (start) begin
                    state_nx = SH_SHIFT;
                end
            end
            SH_SHIFT: begin
                if (phase == PH_LAST && bit_cnt == BIT_LAST) begin
                    state_nx = SH_GAP;
                end
            end
            SH_GAP: begin
                if (gap_cnt == GAP_LAST) begin
                    state_nx = SH_IDLE;
                end
            end
            default: state_nx = SH_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase   <= '0;
            bit_cnt <= '0;
            gap_cnt <= '0;
            shreg   <= '0;
            rx      <= '0;
        end else begin
            if (state == SH_IDLE && start) begin
                shreg   <= frame;
                phase   <= '0;
                bit_cnt <= '0;
            end
            if (state == SH_SHIFT) begin
                phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
                if (phase == PH_SAMP) begin
                    rx <= {rx[SDATA_W-2:0], miso};
                end
                if (phase == PH_LAST) begin
                    shreg   <= {shreg[FRAME_W-2:0], 1'b0};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
            if (state == SH_GAP) begin
                gap_cnt <= gap_cnt + 1'b1;
            end else begin
                gap_cnt <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        csn     = (state != SH_SHIFT);
        sclk    = (state == SH_SHIFT) && (phase >= PH_HIGH);
        mosi    = (state == SH_SHIFT) && shreg[FRAME_W-1];
        done    = (state == SH_GAP) && (gap_cnt == GAP_LAST);
        rx_data = rx;
    end

endmodule

// File: rtl/bridge_seq.sv
`timescale 1ns/1ps
module bridge_seq
    import pmic_bridge_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_empty,
    input  wr_entry_t          fifo_head,
    input  logic               rd_pend,
    input  logic [SADDR_W-1:0] rd_addr,
    input  logic               sh_done,
    output logic               fifo_pop,
    output logic               sh_start,
    output logic               sh_rw,
    output logic [FRAME_W-1:0] sh_frame,
    output logic               rd_complete
);
    ctl_state_t state;
    ctl_state_t state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= C_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // outputs and transitions; queued writes win over a pending read
    always_comb begin
        state_nx    = state;
        fifo_pop    = 1'b0;
        sh_start    = 1'b0;
        sh_rw       = 1'b0;
        sh_frame    = {1'b0, fifo_head};
        rd_complete = 1'b0;
        unique case (state)
            C_IDLE: begin
                if (!fifo_empty) begin
                    fifo_pop = 1'b1;
                    sh_start = 1'b1;
                    state_nx = C_WR;
                end else if (rd_pend) begin
                    sh_start = 1'b1;
                    sh_rw    = 1'b1;
                    sh_frame = {1'b1, rd_addr, {SDATA_W{1'b0}}};
                    state_nx = C_RD;
                end
            end
            C_WR: begin
                if (sh_done) begin
                    state_nx = C_IDLE;
                end
            end
            C_RD: begin
                if (sh_done) begin
                    rd_complete = 1'b1;
                    state_nx    = C_IDLE;
                end
            end
            default: state_nx = C_IDLE;
        endcase
    end

endmodule

// File: rtl/pmic_bridge.sv
`timescale 1ns/1ps
module pmic_bridge
    import pmic_bridge_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int CLK_DIV    = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [15:0] bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        link_sclk,
    output logic        link_csn,
    output logic        link_mosi,
    input  logic        link_miso
);
    localparam int ECHO_PAD = 15 - SADDR_W;

    logic               host_wr;
    logic               push_req;
    logic               cmd_wr;
    wr_entry_t          push_ent;
    wr_entry_t          fifo_head;
    logic               fifo_full;
    logic               fifo_empty;
    logic               fifo_pop;
    logic               ovf_q;
    logic               rd_busy;
    logic [SADDR_W-1:0] rd_req_addr;
    logic [SADDR_W-1:0] rd_echo_q;
    logic [SDATA_W-1:0] rd_data_q;
    logic               sh_start;
    logic               sh_rw;
    logic [FRAME_W-1:0] sh_frame;
    logic               sh_done;
    logic [SDATA_W-1:0] sh_rx;
    logic               rd_complete;
    logic [31:0]        rd_word;
    logic [31:0]        sts_word;

    // host decode
    assign host_wr  = bus_sel && bus_wr;
    assign push_req = host_wr && (bus_addr[15:12] == WIN_TAG);
    assign cmd_wr   = host_wr && (bus_addr == OFF_RD_CMD);
    assign push_ent = '{addr: bus_addr[SADDR_W-1:0], data: bus_wdata[SDATA_W-1:0]};

    bridge_wfifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (ENTRY_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_req),
        .push_data (push_ent),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    bridge_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_empty  (fifo_empty),
        .fifo_head   (fifo_head),
        .rd_pend     (rd_busy),
        .rd_addr     (rd_req_addr),
        .sh_done     (sh_done),
        .fifo_pop    (fifo_pop),
        .sh_start    (sh_start),
        .sh_rw       (sh_rw),
        .sh_frame    (sh_frame),
        .rd_complete (rd_complete)
    );

    bridge_link_shifter #(
        .CLK_DIV (CLK_DIV)
    ) u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .frame   (sh_frame),
        .done    (sh_done),
        .rx_data (sh_rx),
        .sclk    (link_sclk),
        .csn     (link_csn),
        .mosi    (link_mosi),
        .miso    (link_miso)
    );

    // sticky overflow and read-command registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q       <= 1'b0;
            rd_busy     <= 1'b0;
            rd_req_addr <= '0;
            rd_echo_q   <= '0;
            rd_data_q   <= '0;
        end else begin
            if (push_req && fifo_full) begin
                ovf_q <= 1'b1;
            end
            if (rd_complete) begin
                rd_busy   <= 1'b0;
                rd_echo_q <= rd_req_addr;
                rd_data_q <= sh_rx;
            end else if (cmd_wr && !rd_busy) begin
                rd_busy     <= 1'b1;
                rd_req_addr <= bus_wdata[SADDR_W-1:0];
            end
        end
    end

    // host readback
    always_comb begin
        rd_word  = {rd_busy, {ECHO_PAD{1'b0}}, rd_echo_q, rd_data_q};
        sts_word = '0;
        sts_word[STS_FULL_BIT]  = fifo_full;
        sts_word[STS_EMPTY_BIT] = fifo_empty;
        sts_word[STS_OVF_BIT]   = ovf_q;
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == OFF_RD_DATA) begin
                bus_rdata = rd_word;
            end else if (bus_addr == OFF_FIFO_STS) begin
                bus_rdata = sts_word;
            end
        end
    end

endmodule

// File: rtl/pmic_bridge_checker.sv
`timescale 1ns/1ps
module pmic_bridge_checker (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic csn,
    input logic cmd_wr,
    input logic rd_busy,
    input logic fifo_full,
    input logic fifo_empty,
    input logic ovf,
    input logic push_req,
    input logic sh_start,
    input logic sh_rw
);
    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty)); // R4

    AST_DROP_FLAGS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && fifo_full) |=> ovf); // R4

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf); // R4

    AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_busy) |-> $past(cmd_wr)); // R5

    AST_READ_AFTER_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_start && sh_rw) |-> fifo_empty); // R8

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        csn |-> !sclk); // R9

    AST_SCLK_HIGH_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |=> sclk); // R9

    AST_SCLK_LOW_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sclk) && !csn) |=> !sclk); // R9

endmodule

bind pmic_bridge pmic_bridge_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk       (link_sclk),
    .csn        (link_csn),
    .cmd_wr     (cmd_wr),
    .rd_busy    (rd_busy),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .ovf        (ovf_q),
    .push_req   (push_req),
    .sh_start   (sh_start),
    .sh_rw      (sh_rw)
);

// File: tb/pmic_bridge_test.sv
`timescale 1ns/1ps
module pmic_bridge_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        link_sclk;
    logic        link_csn;
    logic        link_mosi;
    logic        link_miso = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    pmic_bridge uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .link_sclk (link_sclk),
        .link_csn  (link_csn),
        .link_mosi (link_mosi),
        .link_miso (link_miso)
    );

    localparam logic [15:0] A_CMD = 16'h0028;
    localparam logic [15:0] A_RES = 16'h002C;
    localparam logic [15:0] A_STS = 16'h0030;

    int n_tests = 0;
    int n_fail  = 0;

    function automatic logic [15:0] init_val(input int a);
        return 16'(a * 40503) ^ 16'h5A5A;
    endfunction

    function automatic logic [31:0] exp_result(input logic [11:0] a, input logic [15:0] d);
        return {4'h0, a, d};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- behavioural slave ----------------
    logic [15:0] sl_mem [4096];
    logic [28:0] sl_shift = '0;
    logic [15:0] sl_rword = '0;
    logic        sl_rw = 1'b0;
    logic        sl_active = 1'b0;
    int          sl_cnt = 0;
    int          frames = 0;
    int          frame_err = 0;
    logic [11:0] log_a [256];
    logic [15:0] log_d [256];
    int          log_n = 0;

    initial begin
        for (int i = 0; i < 4096; i++) sl_mem[i] = init_val(i);
    end

    always @(negedge link_csn) begin
        sl_cnt = 0;
        sl_active = 1'b1;
    end

    always @(posedge link_sclk) begin
        if (!link_csn) begin
            sl_shift = {sl_shift[27:0], link_mosi};
            sl_cnt++;
            if (sl_cnt == 13) begin
                sl_rw = sl_shift[12];
                sl_rword = sl_mem[sl_shift[11:0]];
            end
        end
    end

    always @(negedge link_sclk) begin
        if (!link_csn && sl_rw && sl_cnt >= 13 && sl_cnt < 29)
            link_miso = sl_rword[28 - sl_cnt];
    end

    always @(posedge link_csn) begin
        if (sl_active) begin
            sl_active = 1'b0;
            frames++;
            if (sl_cnt != 29) frame_err++;
            else if (!sl_shift[28]) begin
                sl_mem[sl_shift[27:16]] = sl_shift[15:0];
                if (log_n < 256) begin
                    log_a[log_n] = sl_shift[27:16];
                    log_d[log_n] = sl_shift[15:0];
                end
                log_n++;
            end
        end
    end

    // ---------------- link timing monitor (R9) ----------------
    int   t_err = 0;
    int   run = 0;
    int   gap = 100;
    logic lvl = 1'b0;
    logic prev_csn = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (link_csn) begin
                if (link_sclk) t_err++;
                gap++;
            end else if (prev_csn) begin
                if (gap < 4) t_err++;
                if (link_sclk) t_err++;
                gap = 0;
                run = 1;
                lvl = link_sclk;
            end else if (link_sclk == lvl) begin
                run++;
            end else begin
                if (run != 2) t_err++;
                run = 1;
                lvl = link_sclk;
            end
            prev_csn = link_csn;
        end
    end

    // ---------------- bench model ----------------
    logic [15:0] exp_mem [4096];
    logic [11:0] exp_a [256];
    logic [15:0] exp_d [256];
    int          exp_n = 0;

    task automatic bwrite(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [15:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic note_write(input logic [11:0] a, input logic [15:0] d);
        exp_mem[a] = d;
        if (exp_n < 256) begin
            exp_a[exp_n] = a;
            exp_d[exp_n] = d;
        end
        exp_n++;
    endtask

    task automatic push_wr(input logic [11:0] a, input logic [15:0] d);
        logic [31:0] s;
        for (int k = 0; k < 5000; k++) begin
            bread(A_STS, s);
            if (!s[11]) break;
        end
        bwrite({4'h8, a}, d);
        note_write(a, d);
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        logic [31:0] r;
        bit ok = 1'b0;
        for (int k = 0; k < 20000; k++) begin
            bread(A_STS, s);
            bread(A_RES, r);
            if (s[10] && !r[31] && link_csn && log_n == exp_n) begin
                ok = 1'b1;
                break;
            end
        end
        if (!ok) chk(1'b0, "idle wait", 32'(log_n), 32'(exp_n));
    endtask

    task automatic check_log(input string req);
        bit ok = (log_n == exp_n);
        logic [31:0] act = 32'(log_n);
        logic [31:0] exp = 32'(exp_n);
        for (int i = 0; i < exp_n && i < 256 && ok; i++) begin
            if (log_a[i] != exp_a[i] || log_d[i] != exp_d[i]) begin
                ok = 1'b0;
                act = {4'h0, log_a[i], log_d[i]};
                exp = {4'h0, exp_a[i], exp_d[i]};
            end
        end
        chk(ok, req, act, exp);
    endtask

    task automatic read_wait(output logic [31:0] r);
        for (int k = 0; k < 20000; k++) begin
            bread(A_RES, r);
            if (!r[31]) break;
        end
    endtask

    task automatic print_summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=done", 150000);
        print_summary();
        $finish;
    end

    initial begin
        logic [31:0] s;
        logic [31:0] r;
        int          f0;
        int          seed;
        seed = $urandom(32'h5EED_1234);
        for (int i = 0; i < 4096; i++) exp_mem[i] = init_val(i);

        repeat (5) @(negedge clk);
        // R1: reset state
        bread(A_RES, r);
        chk(r == 32'h0, "R1 result word at reset", r, 32'h0);
        bread(A_STS, s);
        chk(s == 32'h400, "R1 status at reset", s, 32'h400);
        chk(link_csn && !link_sclk, "R1 link idle in reset", {link_csn, link_sclk}, 2'b10);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2: single window write frame
        push_wr(12'hA5C, 16'h1234);
        wait_idle();
        check_log("R2 single write frame");

        // R2: writes outside the window produce nothing
        f0 = frames;
        bwrite(16'h9A5C, 16'hDEAD);
        bwrite(16'h1000, 16'hBEEF);
        bwrite(16'h7FFE, 16'hCAFE);
        repeat (200) @(negedge clk);
        chk(frames == f0, "R2 out-of-window writes ignored", 32'(frames), 32'(f0));
        bread(A_STS, s);
        chk(s == 32'h400, "R2 status unchanged by ignored writes", s, 32'h400);

        // R4 / R3: burst of ten pushes; one leaves at once, eight fill, the tenth drops
        for (int i = 0; i < 10; i++) begin
            bwrite({4'h8, 12'(12'h100 + i)}, 16'(16'hC000 + i));
            if (i < 9) note_write(12'(12'h100 + i), 16'(16'hC000 + i));
        end
        bread(A_STS, s);
        chk(s == 32'h801, "R4 full with sticky overflow", s, 32'h801);
        wait_idle();
        check_log("R3 burst order, dropped tenth push");
        bread(A_STS, s);
        chk(s == 32'h401, "R4 overflow stays after draining", s, 32'h401);

        // R5 / R6: directed read
        bwrite(A_CMD, 16'h0A5C);
        bread(A_RES, r);
        chk(r[31], "R5 busy right after command", r, 32'h8000_0000);
        repeat (60) @(negedge clk);
        bread(A_RES, r);
        chk(r[31], "R5 busy held mid-frame", r, 32'h8000_0000);
        read_wait(r);
        chk(r == exp_result(12'hA5C, 16'h1234), "R6 read result word", r, exp_result(12'hA5C, 16'h1234));

        // R7: second command during busy is ignored
        f0 = frames;
        bwrite(A_CMD, 16'h0321);
        bwrite(A_CMD, 16'h0777);
        read_wait(r);
        chk(r == exp_result(12'h321, exp_mem[12'h321]), "R7 result from first command", r,
            exp_result(12'h321, exp_mem[12'h321]));
        repeat (300) @(negedge clk);
        chk(frames == f0 + 1, "R7 no extra frame", 32'(frames), 32'(f0 + 1));
        bread(A_RES, r);
        chk(r == exp_result(12'h321, exp_mem[12'h321]), "R7 result not disturbed", r,
            exp_result(12'h321, exp_mem[12'h321]));

        // R8: read right behind queued writes to the same register
        bwrite({4'h8, 12'h155}, 16'h1111); note_write(12'h155, 16'h1111);
        bwrite({4'h8, 12'h156}, 16'h2222); note_write(12'h156, 16'h2222);
        bwrite({4'h8, 12'h155}, 16'hBEEF); note_write(12'h155, 16'hBEEF);
        bwrite(A_CMD, 16'h0155);
        read_wait(r);
        chk(r == exp_result(12'h155, 16'hBEEF), "R8 read after queued writes", r,
            exp_result(12'h155, 16'hBEEF));

        // random mix
        for (int i = 0; i < 40; i++) begin
            logic [11:0] a;
            logic [15:0] d;
            a = ($urandom % 2 == 0) ? 12'($urandom % 16) : 12'($urandom % 4096);
            d = 16'($urandom);
            if ($urandom % 3 != 0) begin
                push_wr(a, d);
            end else begin
                read_wait(r);
                bwrite(A_CMD, {4'h0, a});
                read_wait(r);
                chk(r == exp_result(a, exp_mem[a]), "R6 random read", r, exp_result(a, exp_mem[a]));
            end
        end
        wait_idle();
        check_log("R3 random write order");

        // R9: link timing over the whole run
        chk(t_err == 0, "R9 clock and select timing", 32'(t_err), 32'h0);
        chk(frame_err == 0, "R9 frame length 29 bits", 32'(frame_err), 32'h0);

        print_summary();
        $finish;
    end

endmodule